// File: doc/BRIEF.md
# Configurable Event Router

The block takes a vector of event lines and fans them out to a small set of request outputs, each usable as an interrupt or wake-up line. Every input has a polarity bit and a mode bit. In direct mode the event follows the active level of its line. In latched mode an active edge captures the event, and it stays set until software clears it.

Two mask levels gate each event. A global enable per input passes or blocks the input for every output at once. Each output also has its own enable vector, so an input can reach some outputs and not others. Software reaches the configuration, the latch clear, the raw event vector and the per-output detect status through a plain single-cycle register port. Reads are combinational and writes take effect at the clock edge. Every register is NUM_IN bits wide, one bit per input.

Top module: `evt_router`

## Requirements
- R1: After reset, every register reads zero and every `irq_o` bit is low: all inputs are masked, all latches are clear and every input is in direct mode with active-high polarity.
- R2: In direct mode (mode bit 0, register at address 1), bit i of the raw register (address 4, read-only) equals the active level of `evt_i[i]` in the same cycle.
- R3: The polarity register (address 0) selects the active level of each input: bit 1 means active-low, bit 0 means active-high. This applies in both modes. A polarity write that makes the level active counts as an active edge.
- R4: In latched mode (mode bit 1), the latch bit (address 3) sets on the clock edge after an inactive-to-active change of the level. It stays set after the input goes inactive. A level that stays active does not set the bit again once it has been cleared.
- R5: Writing to address 3 clears the latch bits written as 1 and leaves the bits written as 0 unchanged.
- R6: When an active edge and a clear of the same bit happen in the same cycle, the latch bit stays set.
- R7: When the global enable bit of an input (address 2) is 0, the input reaches no output.
- R8: Output k's enable vector sits at address 8+k. An input reaches output k only when its bit is 1 there and its global enable bit is also 1.
- R9: The status register of output k, at address 8+NUM_OUT+k, reads raw AND global enable AND the enable vector of output k.
- R10: `irq_o[k]` is registered. It is high in the cycle after the status of output k has any bit set.
- R11: The raw register shows events whatever the mask settings are.
- R12: Latch bits of inputs in direct mode clear on the second clock edge after the mode write. In direct mode the latch register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_IN | Event lines, synchronous to clk_i |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW | Register address |
| wdata_i | input | NUM_IN | Write data |
| rdata_o | output | NUM_IN | Read data for addr_i, combinational |
| irq_o | output | NUM_OUT | Request outputs, one per output |

## Verification
The bench builds the block with NUM_IN = 8 and NUM_OUT = 2. With these values every one of the 256 input patterns can be driven in direct mode under four different sets of polarity, global and per-output masks. For each pattern the bench checks the raw register, both status registers and both request lines against values it computes arithmetically. The narrow width also makes the latched-mode cases easy to follow bit by bit: edge capture, partial clear, the same-cycle set and clear, the edge caused by a polarity write, and the clearing that follows a mode switch.

// File: rtl/evt_router_pkg.sv
package evt_router_pkg;
  localparam int REG_POL   = 0;
  localparam int REG_MODE  = 1;
  localparam int REG_GEN   = 2;
  localparam int REG_LATCH = 3;
  localparam int REG_RAW   = 4;
  localparam int OUT_BASE  = 8;

  function automatic int addr_width(input int num_out);
    return $clog2(OUT_BASE + 2 * num_out);
  endfunction
endpackage

// File: rtl/evt_capture.sv
module evt_capture #(
  parameter int NUM_IN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IN-1:0] evt_i,
  input  logic [NUM_IN-1:0] pol_i,
  input  logic [NUM_IN-1:0] mode_i,
  input  logic [NUM_IN-1:0] clr_i,
  output logic [NUM_IN-1:0] rise_o,
  output logic [NUM_IN-1:0] latch_o,
  output logic [NUM_IN-1:0] raw_o
);
  logic [NUM_IN-1:0] level, level_q, latch_q;

  assign level = evt_i ^ pol_i;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_bit
    assign rise_o[i] = level[i] & ~level_q[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        level_q[i] <= 1'b0;
        latch_q[i] <= 1'b0;
      end else begin
        level_q[i] <= level[i];
        // an edge wins over a clear in the same cycle
        latch_q[i] <= mode_i[i] & ((latch_q[i] & ~clr_i[i]) | rise_o[i]);
      end
    end

    assign raw_o[i] = mode_i[i] ? latch_q[i] : level[i];
  end

  assign latch_o = latch_q;
endmodule

// File: rtl/evt_regs.sv
module evt_regs
  import evt_router_pkg::*;
#(
  parameter int NUM_IN  = 32,
  parameter int NUM_OUT = 4,
  parameter int AW      = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [AW-1:0]                   addr_i,
  input  logic [NUM_IN-1:0]               wdata_i,
  output logic [NUM_IN-1:0]               rdata_o,
  output logic [NUM_IN-1:0]               pol_o,
  output logic [NUM_IN-1:0]               mode_o,
  output logic [NUM_IN-1:0]               gen_o,
  output logic [NUM_OUT-1:0][NUM_IN-1:0]  out_en_o,
  output logic [NUM_IN-1:0]               clr_o,
  input  logic [NUM_IN-1:0]               latch_i,
  input  logic [NUM_IN-1:0]               raw_i,
  input  logic [NUM_OUT-1:0][NUM_IN-1:0]  st_i
);
  localparam int ST_BASE = OUT_BASE + NUM_OUT;

  logic sel_pol, sel_mode, sel_gen, sel_latch;

  assign sel_pol   = wr_en_i && (addr_i == AW'(REG_POL));
  assign sel_mode  = wr_en_i && (addr_i == AW'(REG_MODE));
  assign sel_gen   = wr_en_i && (addr_i == AW'(REG_GEN));
  assign sel_latch = wr_en_i && (addr_i == AW'(REG_LATCH));

  assign clr_o = sel_latch ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_o  <= '0;
      mode_o <= '0;
      gen_o  <= '0;
    end else begin
      if (sel_pol)  pol_o  <= wdata_i;
      if (sel_mode) mode_o <= wdata_i;
      if (sel_gen)  gen_o  <= wdata_i;
    end
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out_en
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        out_en_o[k] <= '0;
      else if (wr_en_i && (addr_i == AW'(OUT_BASE + k)))
        out_en_o[k] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(REG_POL))   rdata_o = pol_o;
    if (addr_i == AW'(REG_MODE))  rdata_o = mode_o;
    if (addr_i == AW'(REG_GEN))   rdata_o = gen_o;
    if (addr_i == AW'(REG_LATCH)) rdata_o = latch_i;
    if (addr_i == AW'(REG_RAW))   rdata_o = raw_i;
    for (int k = 0; k < NUM_OUT; k++) begin
      if (addr_i == AW'(OUT_BASE + k)) rdata_o = out_en_o[k];
      if (addr_i == AW'(ST_BASE + k))  rdata_o = st_i[k];
    end
  end
endmodule

// File: rtl/evt_route.sv
module evt_route #(
  parameter int NUM_IN  = 32,
  parameter int NUM_OUT = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_IN-1:0]              raw_i,
  input  logic [NUM_IN-1:0]              gen_i,
  input  logic [NUM_OUT-1:0][NUM_IN-1:0] out_en_i,
  output logic [NUM_OUT-1:0][NUM_IN-1:0] st_o,
  output logic [NUM_OUT-1:0]             hit_o,
  output logic [NUM_OUT-1:0]             irq_o
);
  logic [NUM_IN-1:0] passed;

  assign passed = raw_i & gen_i;

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    assign st_o[k]  = passed & out_en_i[k];
    assign hit_o[k] = |st_o[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_o[k] <= 1'b0;
      else         irq_o[k] <= hit_o[k];
    end
  end
endmodule

// File: rtl/evt_router.sv
module evt_router
  import evt_router_pkg::*;
#(
  parameter int NUM_IN  = 32,
  parameter int NUM_OUT = 4,
  parameter int AW      = addr_width(NUM_OUT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IN-1:0]  evt_i,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [NUM_IN-1:0]  wdata_i,
  output logic [NUM_IN-1:0]  rdata_o,
  output logic [NUM_OUT-1:0] irq_o
);
  logic [NUM_IN-1:0]              pol_q, mode_q, gen_q, clr_w;
  logic [NUM_IN-1:0]              rise_w, latch_q, raw_w;
  logic [NUM_OUT-1:0][NUM_IN-1:0] out_en_q, st_w;
  logic [NUM_OUT-1:0]             hit_w;

  evt_regs #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .AW(AW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .pol_o    (pol_q),
    .mode_o   (mode_q),
    .gen_o    (gen_q),
    .out_en_o (out_en_q),
    .clr_o    (clr_w),
    .latch_i  (latch_q),
    .raw_i    (raw_w),
    .st_i     (st_w)
  );

  evt_capture #(.NUM_IN(NUM_IN)) u_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt_i),
    .pol_i   (pol_q),
    .mode_i  (mode_q),
    .clr_i   (clr_w),
    .rise_o  (rise_w),
    .latch_o (latch_q),
    .raw_o   (raw_w)
  );

  evt_route #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_route (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .raw_i    (raw_w),
    .gen_i    (gen_q),
    .out_en_i (out_en_q),
    .st_o     (st_w),
    .hit_o    (hit_w),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/evt_router_chk.sv
module evt_router_chk #(
  parameter int NUM_IN  = 32,
  parameter int NUM_OUT = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_OUT-1:0] irq_o,
  input logic [NUM_OUT-1:0] hit_w,
  input logic [NUM_IN-1:0]  latch_q,
  input logic [NUM_IN-1:0]  mode_q,
  input logic [NUM_IN-1:0]  clr_w,
  input logic [NUM_IN-1:0]  rise_w,
  input logic [NUM_IN-1:0]  gen_q
);
  AST_RESET_IRQ_LOW: assert property (@(posedge clk_i)
    !rst_ni |-> (irq_o == '0)); // R1

  AST_IRQ_FOLLOWS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(hit_w))); // R10

  AST_GLOBAL_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_q == '0) |=> (irq_o == '0)); // R7

  AST_LATCH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((latch_q & mode_q & ~clr_w) != '0) |=>
      ((latch_q & $past(latch_q & mode_q & ~clr_w)) == $past(latch_q & mode_q & ~clr_w))); // R4

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rise_w & mode_q & clr_w) != '0) |=>
      ((latch_q & $past(rise_w & mode_q & clr_w)) == $past(rise_w & mode_q & clr_w))); // R6
endmodule

bind evt_router evt_router_chk #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .irq_o   (irq_o),
  .hit_w   (hit_w),
  .latch_q (latch_q),
  .mode_q  (mode_q),
  .clr_w   (clr_w),
  .rise_w  (rise_w),
  .gen_q   (gen_q)
);

// File: tb/sim_evt_router.sv
module sim_evt_router;
  localparam int NI = 8;
  localparam int NO = 2;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NI-1:0] evt = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [NI-1:0] wdata = '0;
  logic [NI-1:0] rdata;
  logic [NO-1:0] irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  evt_router #(.NUM_IN(NI), .NUM_OUT(NO), .AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [NI-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int a, input logic [NI-1:0] exp);
    addr = AW'(a);
    #1;
    chk(req, 32'(rdata), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NI-1:0] pol, gen, en0, en1, raw, s0, s1;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", 32'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 12; a++) rd_chk("R1 reset reg", a, '0);
    chk("R1 irq after reset", 32'(irq), 0);

    // direct mode sweep: R2 R3 R7 R8 R9 R10 R11
    for (int c = 0; c < 4; c++) begin
      pol = NI'(c * 37);
      gen = ~(NI'(1) << (c * 2));
      en0 = NI'(8'h55 << c);
      en1 = NI'(8'hF0 >> c);
      if (c == 3) gen = '0;
      wr(0, pol); wr(2, gen); wr(8, en0); wr(9, en1);
      for (int p = 0; p < 256; p++) begin
        @(negedge clk);
        evt = NI'(p);
        raw = NI'(p) ^ pol;
        s0 = raw & gen & en0;
        s1 = raw & gen & en1;
        rd_chk("R2 R3 R11 raw", 4, raw);
        rd_chk("R9 R8 status0", 10, s0);
        rd_chk("R9 R8 status1", 11, s1);
        @(negedge clk);
        chk("R10 R7 irq", 32'(irq), 32'({|s1, |s0}));
      end
    end

    // latched mode
    wr(0, '0); wr(2, '0);
    @(negedge clk); evt = '0;
    wr(1, '1);
    @(negedge clk); evt = 8'h05;
    @(negedge clk); evt = 8'h00;
    @(negedge clk);
    rd_chk("R4 latch held", 3, 8'h05);
    wr(3, 8'h01);
    rd_chk("R5 partial clear", 3, 8'h04);
    @(negedge clk);
    evt = 8'h02; wr_en = 1'b1; addr = AW'(3); wdata = 8'h02;
    @(negedge clk); wr_en = 1'b0;
    rd_chk("R6 edge beats clear", 3, 8'h06);
    wr(3, 8'h02);
    @(negedge clk);
    rd_chk("R4 held level no reset", 3, 8'h04);
    evt = '0;

    wr(2, '1); wr(8, 8'h04); wr(9, 8'h00);
    @(negedge clk);
    chk("R8 latched irq", 32'(irq), 32'h1);
    wr(2, 8'hFB);
    @(negedge clk);
    chk("R7 global block", 32'(irq), 32'h0);
    rd_chk("R11 raw under mask", 4, 8'h04);

    @(negedge clk); evt = 8'h80;
    @(negedge clk);
    wr(0, 8'h80);
    wr(3, 8'h80);
    rd_chk("R3 cleared", 3, 8'h04);
    evt = 8'h00;
    @(negedge clk);
    rd_chk("R3 active-low edge", 3, 8'h84);

    wr(1, '0);
    @(negedge clk);
    rd_chk("R12 direct clears latch", 3, 8'h00);
    rd_chk("R12 raw direct", 4, 8'h80);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule